// File: doc/BRIEF.md
# Card Clock Source and Divider Configurator

This block owns the control word that steers a storage-card clock: a two-bit source select and an eight-bit divider field. A request carries a target frequency in hertz. The block first tries the general PLL as the source, using the truncated ratio of the PLL frequency to the target. Slow identification-phase clocks can need a ratio larger than the divider allows. In that case the block switches to the fixed 24 MHz oscillator and computes the ratio again from that frequency. The chosen select and the ratio minus one go into the low ten bits of the word. All higher bits keep their old value.

A second request type writes a whole control word directly. After either kind of update, the block reports the frequency that the new word implies. One shared iterative restoring divider does every division, so the block accepts one request at a time. A single-cycle done pulse marks the cycle in which both the new word and the readback rate are valid.

Top module: `cardclk_cfg`

## Requirements
- R1: For a rate request, ratio = PLL_HZ / target (truncated). When 1 <= ratio <= 127, the word takes select 1 (general PLL) in bits [9:8] and ratio-1 in bits [7:0].
- R2: When the PLL ratio exceeds 127, the word takes select 2 (oscillator) and ratio = OSC_HZ / target (truncated), with ratio-1 in bits [7:0].
- R3: After every successful update, rate_hz = src / (bits[7:0] + 1). Here src is OSC_HZ when bits [9:8] = 2, and PLL_HZ for select values 0, 1 and 3.
- R4: A rate request leaves bits [31:10] of the control word unchanged.
- R5: A target of zero is answered with done and err one cycle after acceptance. The word and the rate stay unchanged.
- R6: A PLL ratio of zero (target above PLL_HZ) is answered with err. The word and the rate stay unchanged.
- R7: An oscillator ratio above 256, which the eight-bit field cannot hold, is answered with err. The word and the rate stay unchanged.
- R8: done is a one-cycle pulse, and ctrl_word and rate_hz change only in a done cycle. Counting the accepting edge as 1, done is visible after 1 edge for a zero target, 34 for a word write or a zero-ratio error, 67 for a PLL result or an oversize-ratio error, and 100 for an oscillator result.
- R9: busy is high from the edge after acceptance until done. A request presented while busy is ignored.
- R10: After reset, ctrl_word = RESET_WORD, rate_hz = 0, and done, err and busy are 0.
- R11: A write request (req_op = 1) replaces all bits of the control word with req_word. A rate request uses req_op = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_op | input | 1 | 0 = program from target rate, 1 = write raw word |
| req_target_hz | input | 32 | Target card clock frequency in Hz |
| req_word | input | 32 | Raw control word for write requests |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion was a rejection, valid with done |
| ctrl_word | output | 32 | Current control word |
| rate_hz | output | 32 | Frequency implied by ctrl_word |

## Verification
Each result has a fixed latency, set by how many 32-step divisions the request needs. A zero target needs none, a word write or a zero-ratio rejection needs one, a PLL result needs two, and an oscillator fallback needs three. Counting the accepting edge as 1, these give 1, 34, 67 and 100 edges. The bench computes that expected edge count from the request alone and checks that done first appears exactly there. At that point it compares err, the word and the rate against its own integer model. On every other falling edge it checks that the word and the rate still equal the last committed model values, so any early or spurious change is caught.

// File: rtl/cardclk_pkg.sv
package cardclk_pkg;

  // source select codes held in bits [9:8] of the control word
  localparam logic [1:0] SRC_CODEC = 2'd0;
  localparam logic [1:0] SRC_GPLL  = 2'd1;
  localparam logic [1:0] SRC_OSC   = 2'd2;
  localparam logic [1:0] SRC_PHY   = 2'd3;

  // control word field placement
  localparam int DIVF_LSB = 0;
  localparam int DIVF_W   = 8;
  localparam int SELF_LSB = 8;
  localparam int SELF_W   = 2;
  localparam int LOW_W    = SELF_LSB + SELF_W;

  // largest ratio accepted from the PLL before falling back
  localparam int PLL_RATIO_MAX = 127;

  typedef enum logic {
    OP_SET_RATE = 1'b0,
    OP_WR_WORD  = 1'b1
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIV_PLL,
    ST_DIV_OSC,
    ST_READBACK
  } state_e;

endpackage

// File: rtl/cardclk_divider.sv
module cardclk_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, quo_q, sor_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    shifted;
  logic [W:0]    diff;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    diff    = shifted - {1'b0, sor_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      sor_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= dividend;
        sor_q <= divisor;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (!diff[W]) begin
          rem_q <= diff[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quo_q <= {quo_q[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done     = done_q;
  assign quotient = quo_q;

  // R8: the divider completion is a single-cycle pulse
  assert_div_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R6: the sequencer never launches a division by zero
  assert_div_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    start |-> (divisor != '0));

endmodule

// File: rtl/cardclk_field.sv
module cardclk_field
  import cardclk_pkg::*;
#(
  parameter int          WORD_W = 32,
  parameter int          RATE_W = 32,
  parameter logic [31:0] PLL_HZ = 32'd491_520_000,
  parameter logic [31:0] OSC_HZ = 32'd24_000_000
) (
  input  logic [WORD_W-1:0] base_word,
  input  logic [1:0]        pack_sel,
  input  logic [RATE_W-1:0] pack_ratio,
  output logic [WORD_W-1:0] packed_word,
  input  logic [WORD_W-1:0] dec_word,
  output logic [RATE_W-1:0] dec_src_hz,
  output logic [RATE_W-1:0] dec_divisor
);

  logic [RATE_W-1:0] ratio_m1;
  logic [1:0]        dec_sel;
  logic [DIVF_W-1:0] dec_field;

  always_comb begin
    ratio_m1    = pack_ratio - RATE_W'(1);
    packed_word = base_word;
    packed_word[SELF_LSB +: SELF_W] = pack_sel;
    packed_word[DIVF_LSB +: DIVF_W] = ratio_m1[DIVF_W-1:0];
  end

  always_comb begin
    dec_sel     = dec_word[SELF_LSB +: SELF_W];
    dec_field   = dec_word[DIVF_LSB +: DIVF_W];
    dec_divisor = RATE_W'(dec_field) + RATE_W'(1);
    dec_src_hz  = (dec_sel == SRC_OSC) ? RATE_W'(OSC_HZ) : RATE_W'(PLL_HZ);
  end

endmodule

// File: rtl/cardclk_cfg.sv
module cardclk_cfg
  import cardclk_pkg::*;
#(
  parameter int          WORD_W     = 32,
  parameter int          RATE_W     = 32,
  parameter logic [31:0] PLL_HZ     = 32'd491_520_000,
  parameter logic [31:0] OSC_HZ     = 32'd24_000_000,
  parameter logic [31:0] RESET_WORD = 32'hA5A5_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_op,
  input  logic [RATE_W-1:0] req_target_hz,
  input  logic [WORD_W-1:0] req_word,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] ctrl_word,
  output logic [RATE_W-1:0] rate_hz
);

  localparam int OSC_RATIO_MAX = 1 << DIVF_W;

  state_e            state_q, state_d;
  logic [WORD_W-1:0] word_q, word_d, pend_q, pend_d;
  logic [RATE_W-1:0] rate_q, rate_d, tgt_q, tgt_d;
  logic              done_q, done_d, err_q, err_d, set_q, set_d;

  logic              div_start, div_done;
  logic [RATE_W-1:0] div_dend, div_sor, div_quo;

  logic [1:0]        pack_sel;
  logic [WORD_W-1:0] packed_word, dec_word;
  logic [RATE_W-1:0] dec_src_hz, dec_divisor;

  assign pack_sel = (state_q == ST_DIV_OSC) ? SRC_OSC : SRC_GPLL;
  assign dec_word = (state_q == ST_IDLE) ? req_word : packed_word;

  cardclk_field #(
    .WORD_W (WORD_W),
    .RATE_W (RATE_W),
    .PLL_HZ (PLL_HZ),
    .OSC_HZ (OSC_HZ)
  ) u_field (
    .base_word   (word_q),
    .pack_sel    (pack_sel),
    .pack_ratio  (div_quo),
    .packed_word (packed_word),
    .dec_word    (dec_word),
    .dec_src_hz  (dec_src_hz),
    .dec_divisor (dec_divisor)
  );

  cardclk_divider #(.W(RATE_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (div_dend),
    .divisor  (div_sor),
    .done     (div_done),
    .quotient (div_quo)
  );

  always_comb begin
    state_d   = state_q;
    word_d    = word_q;
    pend_d    = pend_q;
    rate_d    = rate_q;
    tgt_d     = tgt_q;
    set_d     = set_q;
    done_d    = 1'b0;
    err_d     = err_q;
    div_start = 1'b0;
    div_dend  = dec_src_hz;
    div_sor   = dec_divisor;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          err_d = 1'b0;
          if (op_e'(req_op) == OP_SET_RATE) begin
            set_d = 1'b1;
            if (req_target_hz == '0) begin
              done_d = 1'b1;
              err_d  = 1'b1;
            end else begin
              tgt_d     = req_target_hz;
              div_start = 1'b1;
              div_dend  = RATE_W'(PLL_HZ);
              div_sor   = req_target_hz;
              state_d   = ST_DIV_PLL;
            end
          end else begin
            set_d     = 1'b0;
            pend_d    = req_word;
            div_start = 1'b1;
            state_d   = ST_READBACK;
          end
        end
      end
      ST_DIV_PLL: begin
        if (div_done) begin
          if (div_quo > RATE_W'(PLL_RATIO_MAX)) begin
            div_start = 1'b1;
            div_dend  = RATE_W'(OSC_HZ);
            div_sor   = tgt_q;
            state_d   = ST_DIV_OSC;
          end else if (div_quo == '0) begin
            done_d  = 1'b1;
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            pend_d    = packed_word;
            div_start = 1'b1;
            state_d   = ST_READBACK;
          end
        end
      end
      ST_DIV_OSC: begin
        if (div_done) begin
          if (div_quo > RATE_W'(OSC_RATIO_MAX) || div_quo == '0) begin
            done_d  = 1'b1;
            err_d   = 1'b1;
            state_d = ST_IDLE;
          end else begin
            pend_d    = packed_word;
            div_start = 1'b1;
            state_d   = ST_READBACK;
          end
        end
      end
      ST_READBACK: begin
        if (div_done) begin
          word_d  = pend_q;
          rate_d  = div_quo;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      word_q  <= WORD_W'(RESET_WORD);
      pend_q  <= '0;
      rate_q  <= '0;
      tgt_q   <= '0;
      set_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      word_q  <= word_d;
      pend_q  <= pend_d;
      rate_q  <= rate_d;
      tgt_q   <= tgt_d;
      set_q   <= set_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign ctrl_word = word_q;
  assign rate_hz   = rate_q;

  // R8: outside a completion the word and rate hold
  assert_word_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(ctrl_word) || done);

  assert_rate_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(rate_hz) || done);

  // R5: a rejection never alters the word
  assert_err_keeps_word_R5: assert property (@(posedge clk) disable iff (rst)
    (done && err) |-> $stable(ctrl_word));

  // R9: completion always leaves the block idle
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2: a rate-derived word only ever selects the PLL or the oscillator
  assert_set_source_R2: assert property (@(posedge clk) disable iff (rst)
    (done && !err && set_q) |->
      (ctrl_word[SELF_LSB +: SELF_W] == SRC_GPLL ||
       ctrl_word[SELF_LSB +: SELF_W] == SRC_OSC));

  // R4: upper bits survive a rate-derived update
  assert_upper_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (done && !err && set_q) |->
      (ctrl_word[WORD_W-1:LOW_W] == $past(ctrl_word[WORD_W-1:LOW_W])));

endmodule

// File: tb/cardclk_cfg_tb.sv
module cardclk_cfg_tb;

  localparam longint PLL = 491_520_000;
  localparam longint OSC = 24_000_000;
  localparam int     W   = 32;
  localparam logic [31:0] RSTW = 32'hA5A5_0000;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_op;
  logic [31:0] req_target_hz;
  logic [31:0] req_word;
  logic        busy, done, err;
  logic [31:0] ctrl_word, rate_hz;

  int tests = 0;
  int fails = 0;
  int mon_fail = 0;
  int cyc = 0;
  logic [31:0] m_word, m_rate;
  logic        mon_on = 1'b0;

  always #2.5 clk = ~clk;

  cardclk_cfg u_dut (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .req_target_hz (req_target_hz),
    .req_word      (req_word),
    .busy          (busy),
    .done          (done),
    .err           (err),
    .ctrl_word     (ctrl_word),
    .rate_hz       (rate_hz)
  );

  // every clock: without done the outputs must equal the last committed model (R8)
  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (ctrl_word !== m_word || rate_hz !== m_rate) begin
        mon_fail++;
        if (mon_fail < 5)
          $display("FAIL R8 idle change word=%h exp=%h rate=%0d exp=%0d",
                   ctrl_word, m_word, rate_hz, m_rate);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired act=%0d exp<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails + mon_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic op, input logic [31:0] tgt,
                        input logic [31:0] wd, input bit intrude);
    longint q, src;
    logic [31:0] ew, er;
    bit ee;
    int el, lat;
    ew = m_word; er = m_rate; ee = 1'b0;
    if (op == 1'b1) begin
      ew = wd;
      src = (wd[9:8] == 2'd2) ? OSC : PLL;
      er = 32'(src / (longint'(wd[7:0]) + 1));
      el = W + 2;
    end else if (tgt == 0) begin
      ee = 1'b1; el = 1;
    end else begin
      q = PLL / longint'(tgt);
      if (q == 0) begin
        ee = 1'b1; el = W + 2;
      end else if (q <= 127) begin
        ew = {m_word[31:10], 2'd1, 8'(q - 1)};
        er = 32'(PLL / q); el = 2 * W + 3;
      end else begin
        q = OSC / longint'(tgt);
        if (q > 256) begin
          ee = 1'b1; el = 2 * W + 3;
        end else begin
          ew = {m_word[31:10], 2'd2, 8'(q - 1)};
          er = 32'(OSC / q); el = 3 * W + 4;
        end
      end
    end
    req_valid = 1'b1; req_op = op; req_target_hz = tgt; req_word = wd;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    req_valid = 1'b0;
    if (el > 1) chk({req, " R9 busy after accept"}, busy, 1);
    while (!done && lat < 400) begin
      if (intrude && lat == 4) begin
        req_valid = 1'b1; req_op = 1'b1; req_word = 32'hFFFF_FFFF;
      end else begin
        req_valid = 1'b0;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk({req, " R8 latency"}, lat, el);
    chk({req, " err"}, err, ee);
    chk({req, " word"}, ctrl_word, ew);
    chk({req, " R3 rate"}, rate_hz, er);
    m_word = ctrl_word; m_rate = rate_hz;
    @(negedge clk);
    chk({req, " R8 done pulse"}, done, 0);
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = 1'b0; req_target_hz = '0; req_word = '0;
    m_word = RSTW; m_rate = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 reset word", ctrl_word, RSTW);
    chk("R10 reset rate", rate_hz, 0);
    chk("R10 reset done", done, 0);
    chk("R10 reset busy", busy, 0);
    mon_on = 1'b1;

    run_op("R1 50MHz", 1'b0, 32'd50_000_000, '0, 1'b0);
    run_op("R1 boundary ratio 127", 1'b0, 32'd3_870_236, '0, 1'b0);
    run_op("R2 ratio 128 fallback", 1'b0, 32'd3_840_000, '0, 1'b0);
    run_op("R2 400kHz", 1'b0, 32'd400_000, '0, 1'b0);
    run_op("R2 osc ratio 256", 1'b0, 32'd93_750, '0, 1'b0);
    run_op("R5 zero target", 1'b0, 32'd0, '0, 1'b0);
    run_op("R6 target above pll", 1'b0, 32'd500_000_000, '0, 1'b0);
    run_op("R7 osc ratio too big", 1'b0, 32'd1_000, '0, 1'b0);
    run_op("R11 write sel3", 1'b1, '0, 32'h0000_0309, 1'b0);
    run_op("R11 write sel0", 1'b1, '0, 32'h1234_5C04, 1'b0);
    run_op("R3 write sel2 ff", 1'b1, '0, 32'hDEAD_BEFF, 1'b0);
    run_op("R4 upper kept 25MHz", 1'b0, 32'd25_000_000, '0, 1'b0);
    chk("R4 upper bits", ctrl_word[31:10], 22'(32'hDEAD_BC00 >> 10));
    run_op("R9 ignored while busy", 1'b1, '0, 32'h0000_0201, 1'b1);
    run_op("R1 after ignore", 1'b0, 32'd100_000_000, '0, 1'b0);

    tests++;
    if (mon_fail != 0) $display("FAIL R8 monitor act=%0d exp=0", mon_fail);
    $display("[TB] %0d tests run, %0d failed", tests, fails + (mon_fail != 0 ? 1 : 0));
    $finish;
  end

endmodule